// File: doc/BRIEF.md
# Multiphase Sine Sample Generator

This block produces three streams of 10-bit sine samples that are phase-split from one another. External DACs turn the streams into voltages that excite the windings of a resolver or synchro phase shifter. A single address register steps through one waveform period of 240 samples. Each channel reads a sine table at that address plus a fixed phase offset. Because every channel is derived from the same register, the phase relation between channels cannot drift.

The rate at which the address steps comes from the master clock, divided by one of eight integer ratios. A 3-bit select input chooses the ratio, which sets the output frequency. A second input chooses between two phase arrangements: three channels 120 degrees apart, or two channels in quadrature. The block loads both settings only when the address wraps, so every period it produces is complete. A one-cycle strobe marks each new sample so the DACs can load it.

Top module: `multiphase_sine_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the address returns to 0, the divider clears, `sampleStrobe` is low and the channel outputs show the codes for address 0 in the mode present at `threePhase`.
- R2: Channel codes are offset binary: a sample at address a has the code floor(511.5 + 511.5·sin(a·1.5°) + 0.5), so 512 is zero, 1023 is the positive peak and 0 is the negative peak.
- R3: The shared address counts 0, 1, …, 239 and returns to 0 on the step after 239, so one output period holds exactly 240 samples.
- R4: Each sample lasts N master-clock cycles, where N = MCLK_HZ / (240·f). The value of `freqSel` gives f: 0→100 Hz, 1→200, 2→300, 3→500, 4→600, 5→750, 6→1000, 7→1500. The first step after reset comes N cycles after reset is released.
- R5: With `threePhase` = 1, channel k (k = 0, 1, 2) shows the code for address (a + 80·k) mod 240.
- R6: With `threePhase` = 0, channel 0 shows address a, channel 1 shows address (a + 60) mod 240, and channel 2 holds the mid-scale code 512.
- R7: The block loads `freqSel` and `threePhase` only during reset and on the step from 239 to 0. The new mode applies from the codes at address 0 on, and the new rate applies from the sample that starts at address 0. A change at any other time has no effect until then.
- R8: `sampleStrobe` is high for exactly one cycle, the cycle right after each address step. The channel outputs change only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| freqSel | input | 3 | Output frequency select (loaded at the period boundary) |
| threePhase | input | 1 | 1 = three channels at 120°, 0 = two channels at 90° (loaded at the period boundary) |
| sampleStrobe | output | 1 | One-cycle pulse marking a new sample |
| chanCode | output | 3×10 | Offset-binary sample code per channel, element k for channel k |

## Verification
The hardest case to reach from the ports is a change of `freqSel` or `threePhase` in the middle of a period. The block must hold off until the 239→0 step. Any fault shows up only as a wrong sample length or wrong channel codes, up to 240 samples later. The bench runs the block at a master clock of 720 kHz, which gives divide ratios of 2 to 30, so that many full periods fit in the run. For every select value, the bench waits until the address is partway through a period, changes both inputs there, and then compares every cycle against its own model until two more wraps have passed. One reset is also applied in the middle of a period.

// File: rtl/mpsg_pkg.sv
package mpsg_pkg;

  // Strobes passed from the rate control to the datapath
  typedef struct packed {
    logic advance;   // step the shared sample address
    logic loadCfg;   // period boundary: load the new phase arrangement
  } mpsgCtrl_t;

  localparam int unsigned NUM_SEL = 8;
  localparam int unsigned NUM_CH  = 3;

  // Output frequency in Hz for each select value
  function automatic int unsigned freqHz(int unsigned sel);
    case (sel)
      0: freqHz = 100;
      1: freqHz = 200;
      2: freqHz = 300;
      3: freqHz = 500;
      4: freqHz = 600;
      5: freqHz = 750;
      6: freqHz = 1000;
      default: freqHz = 1500;
    endcase
  endfunction

endpackage

// File: rtl/mpsg_ctrl.sv
module mpsg_ctrl
  import mpsg_pkg::*;
#(
  parameter int unsigned MCLK_HZ = 7_200_000,
  parameter int unsigned SAMPLES = 240
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] freqSel,
  input  logic       atEnd,
  output mpsgCtrl_t  strobes
);

  // The slowest rate needs the largest ratio
  localparam int unsigned MAX_RATIO = MCLK_HZ / (SAMPLES * freqHz(0));
  localparam int unsigned DIV_W     = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;

  logic [DIV_W-1:0] lastCount [NUM_SEL];
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       activeSel;
  logic             tick;

  // Terminal count for each select value, fixed when the block is built
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_ratio
    localparam int unsigned RATIO = MCLK_HZ / (SAMPLES * freqHz(g));
    assign lastCount[g] = DIV_W'(RATIO - 1);
  end

  assign tick = (divCnt == lastCount[activeSel]);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt    <= '0;
      activeSel <= freqSel;
    end else if (tick) begin
      divCnt <= '0;
      if (atEnd) activeSel <= freqSel;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign strobes.advance = tick;
  assign strobes.loadCfg = tick & atEnd;

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
    divCnt <= lastCount[activeSel]);  // R4
  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (rst)
    tick |=> (divCnt == '0));  // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadCfg |=> $stable(activeSel));  // R7

endmodule

// File: rtl/mpsg_datapath.sv
module mpsg_datapath
  import mpsg_pkg::*;
#(
  parameter int unsigned SAMPLES = 240,
  parameter int unsigned CODE_W  = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          threePhase,
  input  mpsgCtrl_t                     strobes,
  output logic                          atEnd,
  output logic                          sampleStrobe,
  output logic [NUM_CH-1:0][CODE_W-1:0] chanCode
);

  localparam int unsigned ADDR_W  = $clog2(SAMPLES);
  localparam int unsigned IDX_W   = ADDR_W + 1;
  localparam int unsigned OFF_TRI = SAMPLES / 3;
  localparam int unsigned OFF_QUAD = SAMPLES / 4;
  localparam real         MID_R   = real'((1 << CODE_W) - 1) / 2.0;
  localparam real         PI_R    = 3.141592653589793;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1 << (CODE_W - 1));

  logic [ADDR_W-1:0] addr;
  logic              activeMode;
  logic [CODE_W-1:0] sineTab [SAMPLES];

  // Sine table computed when the block is built, one entry per sample step
  for (genvar g = 0; g < SAMPLES; g++) begin : g_tab
    localparam real ANG  = 2.0 * PI_R * real'(g) / real'(SAMPLES);
    localparam real SRAW = $sin(ANG);
    localparam real SCLN = (SRAW < 1.0e-9 && SRAW > -1.0e-9) ? 0.0 : SRAW;
    localparam int  CODEV = $rtoi($floor(MID_R + MID_R * SCLN + 0.5));
    assign sineTab[g] = CODE_W'(CODEV);
  end

  assign atEnd = (addr == ADDR_W'(SAMPLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr         <= '0;
      activeMode   <= threePhase;
      sampleStrobe <= 1'b0;
    end else begin
      sampleStrobe <= strobes.advance;
      if (strobes.advance) addr <= atEnd ? '0 : addr + ADDR_W'(1);
      if (strobes.loadCfg) activeMode <= threePhase;
    end
  end

  // Per-channel phase offset: add it to the address and take the result modulo the period
  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    logic [IDX_W-1:0]  sum;
    logic [ADDR_W-1:0] idx;
    always_comb begin
      sum = {1'b0, addr} + (activeMode ? IDX_W'(k * OFF_TRI) : IDX_W'(k * OFF_QUAD));
      if (sum >= IDX_W'(SAMPLES)) sum = sum - IDX_W'(SAMPLES);
      idx = sum[ADDR_W-1:0];
    end
    if (k == NUM_CH - 1) begin : g_last
      assign chanCode[k] = activeMode ? sineTab[idx] : MID_CODE;
    end else begin : g_other
      assign chanCode[k] = sineTab[idx];
    end
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    addr < ADDR_W'(SAMPLES));  // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && !atEnd) |=> (addr == $past(addr) + ADDR_W'(1)));  // R3
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && atEnd) |=> (addr == '0));  // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.advance |=> $stable(addr));  // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadCfg |=> $stable(activeMode));  // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |=> !sampleStrobe);  // R8

endmodule

// File: rtl/multiphase_sine_gen.sv
module multiphase_sine_gen
  import mpsg_pkg::*;
#(
  parameter int unsigned MCLK_HZ = 7_200_000,
  parameter int unsigned SAMPLES = 240,
  parameter int unsigned CODE_W  = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [2:0]                    freqSel,
  input  logic                          threePhase,
  output logic                          sampleStrobe,
  output logic [NUM_CH-1:0][CODE_W-1:0] chanCode
);

  mpsgCtrl_t strobes;
  logic      atEnd;

  mpsg_ctrl #(
    .MCLK_HZ (MCLK_HZ),
    .SAMPLES (SAMPLES)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .freqSel (freqSel),
    .atEnd   (atEnd),
    .strobes (strobes)
  );

  mpsg_datapath #(
    .SAMPLES (SAMPLES),
    .CODE_W  (CODE_W)
  ) dp_i (
    .clk          (clk),
    .rst          (rst),
    .threePhase   (threePhase),
    .strobes      (strobes),
    .atEnd        (atEnd),
    .sampleStrobe (sampleStrobe),
    .chanCode     (chanCode)
  );

  AST_CODES_STABLE: assert property (@(posedge clk) disable iff (rst)
    !sampleStrobe |-> $stable(chanCode));  // R8

endmodule

// File: tb/multiphase_sine_gen_tb_top.sv
module multiphase_sine_gen_tb_top;

  localparam int MCLK = 720_000;
  localparam int NS   = 240;
  localparam int CW   = 10;

  logic               clk = 1'b0;
  logic               rst;
  logic [2:0]         freqSel;
  logic               threePhase;
  logic               sampleStrobe;
  logic [2:0][CW-1:0] chanCode;

  int vectors = 0;
  int fails   = 0;

  // Reference model state
  int cnt, expAddr, expSel, wraps;
  bit expMode, expStrobe;

  always #10 clk = ~clk;

  multiphase_sine_gen #(
    .MCLK_HZ (MCLK),
    .SAMPLES (NS),
    .CODE_W  (CW)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .freqSel      (freqSel),
    .threePhase   (threePhase),
    .sampleStrobe (sampleStrobe),
    .chanCode     (chanCode)
  );

  function automatic int hzOf(int s);
    int t [8] = '{100, 200, 300, 500, 600, 750, 1000, 1500};
    return t[s];
  endfunction

  function automatic int ratioOf(int s);
    return MCLK / (NS * hzOf(s));
  endfunction

  // R2: offset-binary rounded sine
  function automatic int sineCode(int a);
    real s;
    s = $sin(2.0 * 3.141592653589793 * real'(a) / real'(NS));
    if (s < 1.0e-9 && s > -1.0e-9) s = 0.0;
    return $rtoi($floor(511.5 + 511.5 * s + 0.5));
  endfunction

  // R5 / R6: channel address from the phase arrangement
  function automatic int chanExp(int k, int a, bit mode);
    if (!mode && k == 2) return 512;
    return sineCode((a + (mode ? 80 * k : 60 * k)) % NS);
  endfunction

  task automatic checkNow();
    vectors++;
    if (sampleStrobe !== expStrobe) begin
      fails++;
      $display("FAIL R4 R8 strobe at addr %0d: actual %b expected %b", expAddr, sampleStrobe, expStrobe);
    end
    for (int k = 0; k < 3; k++) begin
      if (chanCode[k] !== CW'(chanExp(k, expAddr, expMode))) begin
        fails++;
        $display("FAIL %s ch%0d addr %0d mode %0d: actual %0d expected %0d",
                 expMode ? "R2 R5 R7" : "R2 R6 R7", k, expAddr, expMode,
                 chanCode[k], chanExp(k, expAddr, expMode));
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    expStrobe = 1'b0;
    if (rst) begin  // R1
      cnt = 0; expAddr = 0; expSel = int'(freqSel); expMode = threePhase;
    end else begin
      cnt++;
      if (cnt == ratioOf(expSel)) begin  // R4
        cnt = 0;
        expStrobe = 1'b1;
        if (expAddr == NS - 1) begin  // R3 R7
          expAddr = 0; expSel = int'(freqSel); expMode = threePhase; wraps++;
        end else begin
          expAddr++;
        end
      end
    end
    @(negedge clk);
    checkNow();
  endtask

  task automatic runWraps(int n);
    int target = wraps + n;
    while (wraps < target) step();
  endtask

  task automatic runToAddr(int a);
    step();
    while (!(expStrobe && expAddr == a)) step();
  endtask

  initial begin
    #(20 * 190_000);
    fails++;
    $display("FAIL R3 watchdog: actual run still going expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wraps = 0; cnt = 0; expAddr = 0; expSel = 7; expMode = 1'b1; expStrobe = 1'b0;
    rst = 1'b1; freqSel = 3'd7; threePhase = 1'b1;
    @(negedge clk);
    repeat (3) step();            // R1 reset state, three-phase codes
    rst = 1'b0;
    runWraps(2);                  // R3 R4 fastest rate, full periods

    // R7: change rate and mode in mid-period for every select value
    for (int s = 0; s < 8; s++) begin
      runToAddr(100);
      freqSel    = 3'(s);
      threePhase = s[0];
      runWraps(2);
    end

    // R1: reset in mid-period, then resume in two-phase mode at a middle rate
    runToAddr(37);
    rst = 1'b1; freqSel = 3'd3; threePhase = 1'b0;
    repeat (2) step();
    rst = 1'b0;
    runWraps(1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule